// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for precision time stamping. It runs on a reference clock of known frequency. On every reference cycle it adds a programmable fixed-point increment, in nanoseconds, to a nanosecond accumulator. When the accumulator reaches one full second it moves into a 32-bit seconds counter. The part above one second stays in the accumulator, so no time is lost at the boundary. The whole and fractional parts of the increment are both kept, which lets a software servo trim the frequency by rewriting the increment at any time.

Software sets the time with a load strobe that supplies seconds and nanoseconds. A snapshot request returns one packed word that holds seconds and nanoseconds, both taken in the same cycle, so a reader never sees a torn value across a second boundary. A pulse-per-second output has programmable high and low durations in nanoseconds. It is pulled back into step at every second boundary and on every load, so its rising edge lines up with the start of each second.

Top module: `ptp_tod_counter`

## Requirements
- R1: The increment is a 32.32 fixed-point count of nanoseconds per reference cycle: bits [63:32] hold whole nanoseconds and bits [31:0] the fraction. It is added to the accumulator on every cycle that has no load. After reset the increment is 8.0 ns (0x0000_0008_0000_0000).
- R2: The nanosecond count wraps at the moment the sum reaches 1,000,000,000. A count of 999,999,999 is held and shown. A sum of exactly 1,000,000,000 becomes 0. The count never shows a value of 10^9 or more.
- R3: On a wrap the nanosecond count, including its fraction, takes the sum minus 10^9. The excess is kept and is not forced to zero.
- R4: The 32-bit seconds counter goes up by one on each wrap. `sec_tick` is high for one cycle, in the same cycle that the incremented value first appears.
- R5: An increment written on one clock edge is used from the following edge onward. The accumulated fraction is carried through the change without loss.
- R6: A load sets seconds and whole nanoseconds, and clears the fraction. It replaces the accumulation in that cycle, and no wrap or tick comes from it.
- R7: A cycle with `snap_req` high produces `snap_valid` high on the next cycle, with `snap_ts` = {seconds in [63:32], nanoseconds in [31:0]}. Both fields are the values held just before the sampling edge. `snap_valid` is low after a cycle without a request.
- R8: The PPS phase moves forward by the increment on each cycle. When it reaches high+low whole nanoseconds, one period is subtracted. `pps_out` is high while the phase is below the high duration. New durations apply from the edge after the write, and both reset to 500,000,000 ns.
- R9: On each nanosecond wrap and on each load, the PPS phase is set to the new nanosecond count, so `pps_out` rises at every second boundary.
- R10: After reset, seconds, nanoseconds, fraction and PPS phase are zero. `snap_valid` and `sec_tick` are low and `pps_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| comp_wr_en | input | 1 | Writes the increment register |
| comp_wr_data | input | 64 | Increment, 32.32 nanoseconds per cycle |
| load_en | input | 1 | Loads the time of day |
| load_sec | input | 32 | Seconds value to load |
| load_ns | input | 30 | Whole nanoseconds to load |
| pps_wr_en | input | 1 | Writes the PPS durations |
| pps_hi_ns | input | 32 | PPS high duration in whole nanoseconds |
| pps_lo_ns | input | 32 | PPS low duration in whole nanoseconds |
| snap_req | input | 1 | Requests a coherent timestamp |
| snap_valid | output | 1 | Timestamp valid, one cycle after the request |
| snap_ts | output | 64 | Packed seconds/nanoseconds timestamp |
| sec_tick | output | 1 | One-cycle pulse on each second increment |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
The assertions rely on three limits on the inputs. The whole-nanosecond part of any increment written is below 10^9. Any loaded nanosecond value is below 10^9. The PPS period written is not zero. With these limits a single subtraction always brings a sum back into range. The random stimulus stays inside them: increments are drawn below 300,000,000 ns, loads are taken modulo 10^9, and each PPS duration is drawn between 200,000,000 and 600,000,000 ns, so the increment never reaches a PPS period.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;
  localparam int unsigned DEF_NS_W = 30;
  localparam int unsigned DEF_FRAC_W = 32;
  localparam int unsigned DEF_COMP_INT_W = 32;
  localparam int unsigned DEF_SEC_W = 32;
  localparam int unsigned DEF_HALF_W = 32;
  localparam int unsigned STAMP_NS_W = 32;
endpackage

// File: rtl/ptp_rst_sync.sv
module ptp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptp_ns_accum.sv
module ptp_ns_accum
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_W       = DEF_NS_W,
  parameter int unsigned FRAC_W     = DEF_FRAC_W,
  parameter int unsigned COMP_INT_W = DEF_COMP_INT_W,
  parameter logic [COMP_INT_W+FRAC_W-1:0] COMP_RESET = '0,
  localparam int unsigned COMP_W    = COMP_INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_wr_en,
  input  logic [COMP_W-1:0] comp_wr_data,
  input  logic              load_en,
  input  logic [NS_W-1:0]   load_ns,
  output logic [COMP_W-1:0] comp_q,
  output logic [NS_W-1:0]   ns_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [NS_W-1:0]   ns_d,
  output logic [FRAC_W-1:0] frac_d,
  output logic              wrap
);
  localparam int unsigned ISUM_W = COMP_INT_W + 1;
  localparam logic [ISUM_W-1:0] NS_LIM = ISUM_W'(NS_PER_SEC);

  logic [FRAC_W:0]   frac_sum;
  logic [ISUM_W-1:0] int_sum;
  logic              crossed;

  // next-state: add increment, subtract one second when the limit is reached
  always_comb begin
    frac_sum = {1'b0, frac_q} + {1'b0, comp_q[FRAC_W-1:0]};
    int_sum  = ISUM_W'(ns_q) + ISUM_W'(comp_q[COMP_W-1:FRAC_W])
             + ISUM_W'(frac_sum[FRAC_W]);
    crossed  = (int_sum >= NS_LIM);
    if (load_en) begin
      ns_d   = load_ns;
      frac_d = '0;
      wrap   = 1'b0;
    end else if (crossed) begin
      ns_d   = NS_W'(int_sum - NS_LIM);
      frac_d = frac_sum[FRAC_W-1:0];
      wrap   = 1'b1;
    end else begin
      ns_d   = NS_W'(int_sum);
      frac_d = frac_sum[FRAC_W-1:0];
      wrap   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      ns_q   <= ns_d;
      frac_q <= frac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= COMP_RESET;
    end else if (comp_wr_en) begin
      comp_q <= comp_wr_data;
    end
  end
endmodule

// File: rtl/ptp_sec_counter.sv
module ptp_sec_counter #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] sec_q,
  output logic             tick_q
);
  logic             sec_en;
  logic [SEC_W-1:0] sec_d;

  always_comb begin
    sec_en = load_en | inc;
    sec_d  = load_en ? load_sec : sec_q + SEC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_en) begin
      sec_q <= sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= inc & ~load_en;
    end
  end
endmodule

// File: rtl/ptp_pps_gen.sv
module ptp_pps_gen #(
  parameter int unsigned NS_W       = 30,
  parameter int unsigned FRAC_W     = 32,
  parameter int unsigned COMP_INT_W = 32,
  parameter int unsigned HALF_W     = 32,
  parameter logic [HALF_W-1:0] HI_RESET = '0,
  parameter logic [HALF_W-1:0] LO_RESET = '0,
  localparam int unsigned COMP_W    = COMP_INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [HALF_W-1:0] cfg_hi_ns,
  input  logic [HALF_W-1:0] cfg_lo_ns,
  input  logic [COMP_W-1:0] comp_q,
  input  logic              resync,
  input  logic [NS_W-1:0]   resync_ns,
  input  logic [FRAC_W-1:0] resync_frac,
  output logic              pps_out
);
  localparam int unsigned PH_W  = HALF_W + 1;
  localparam int unsigned ADV_W = (PH_W > COMP_INT_W ? PH_W : COMP_INT_W) + 1;

  logic [HALF_W-1:0] hi_q, lo_q;
  logic [PH_W-1:0]   phase_int_q, phase_int_d;
  logic [FRAC_W-1:0] phase_frac_q, phase_frac_d;
  logic [PH_W-1:0]   period;
  logic [FRAC_W:0]   frac_sum;
  logic [ADV_W-1:0]  adv;

  always_comb begin
    period   = PH_W'(hi_q) + PH_W'(lo_q);
    frac_sum = {1'b0, phase_frac_q} + {1'b0, comp_q[FRAC_W-1:0]};
    adv      = ADV_W'(phase_int_q) + ADV_W'(comp_q[COMP_W-1:FRAC_W])
             + ADV_W'(frac_sum[FRAC_W]);
    if (resync) begin
      phase_int_d  = PH_W'(resync_ns);
      phase_frac_d = resync_frac;
    end else if (adv >= ADV_W'(period)) begin
      phase_int_d  = PH_W'(adv - ADV_W'(period));
      phase_frac_d = frac_sum[FRAC_W-1:0];
    end else begin
      phase_int_d  = PH_W'(adv);
      phase_frac_d = frac_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_int_q  <= '0;
      phase_frac_q <= '0;
    end else begin
      phase_int_q  <= phase_int_d;
      phase_frac_q <= phase_frac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RESET;
      lo_q <= LO_RESET;
    end else if (cfg_wr_en) begin
      hi_q <= cfg_hi_ns;
      lo_q <= cfg_lo_ns;
    end
  end

  assign pps_out = (phase_int_q < PH_W'(hi_q));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NS_W        = DEF_NS_W,
  parameter int unsigned FRAC_W      = DEF_FRAC_W,
  parameter int unsigned COMP_INT_W  = DEF_COMP_INT_W,
  parameter int unsigned SEC_W       = DEF_SEC_W,
  parameter int unsigned HALF_W      = DEF_HALF_W,
  parameter logic [COMP_INT_W+FRAC_W-1:0] COMP_RESET = 64'h0000_0008_0000_0000,
  parameter logic [HALF_W-1:0] PPS_HI_RESET = 32'd500_000_000,
  parameter logic [HALF_W-1:0] PPS_LO_RESET = 32'd500_000_000,
  localparam int unsigned COMP_W  = COMP_INT_W + FRAC_W,
  localparam int unsigned STAMP_W = SEC_W + STAMP_NS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               comp_wr_en,
  input  logic [COMP_W-1:0]  comp_wr_data,
  input  logic               load_en,
  input  logic [SEC_W-1:0]   load_sec,
  input  logic [NS_W-1:0]    load_ns,
  input  logic               pps_wr_en,
  input  logic [HALF_W-1:0]  pps_hi_ns,
  input  logic [HALF_W-1:0]  pps_lo_ns,
  input  logic               snap_req,
  output logic               snap_valid,
  output logic [STAMP_W-1:0] snap_ts,
  output logic               sec_tick,
  output logic               pps_out
);
  logic              rst_sync_n;
  logic [COMP_W-1:0] comp_q;
  logic [NS_W-1:0]   ns_q, ns_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              wrap;
  logic [SEC_W-1:0]  sec_q;
  logic              pps_resync;
  logic [STAMP_W-1:0] snap_d;

  ptp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptp_ns_accum #(
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .COMP_INT_W (COMP_INT_W),
    .COMP_RESET (COMP_RESET)
  ) u_ns_accum (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .comp_wr_en   (comp_wr_en),
    .comp_wr_data (comp_wr_data),
    .load_en      (load_en),
    .load_ns      (load_ns),
    .comp_q       (comp_q),
    .ns_q         (ns_q),
    .frac_q       (frac_q),
    .ns_d         (ns_d),
    .frac_d       (frac_d),
    .wrap         (wrap)
  );

  ptp_sec_counter #(.SEC_W(SEC_W)) u_sec_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .inc      (wrap),
    .load_en  (load_en),
    .load_sec (load_sec),
    .sec_q    (sec_q),
    .tick_q   (sec_tick)
  );

  assign pps_resync = load_en | wrap;

  ptp_pps_gen #(
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .COMP_INT_W (COMP_INT_W),
    .HALF_W     (HALF_W),
    .HI_RESET   (PPS_HI_RESET),
    .LO_RESET   (PPS_LO_RESET)
  ) u_pps_gen (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_wr_en   (pps_wr_en),
    .cfg_hi_ns   (pps_hi_ns),
    .cfg_lo_ns   (pps_lo_ns),
    .comp_q      (comp_q),
    .resync      (pps_resync),
    .resync_ns   (ns_d),
    .resync_frac (frac_d),
    .pps_out     (pps_out)
  );

  // both fields captured from the same register edge
  assign snap_d = {sec_q, STAMP_NS_W'(ns_q)};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      snap_ts <= '0;
    end else if (snap_req) begin
      snap_ts <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      snap_valid <= 1'b0;
    end else begin
      snap_valid <= snap_req;
    end
  end
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_W       = DEF_NS_W,
  parameter int unsigned FRAC_W     = DEF_FRAC_W,
  parameter int unsigned COMP_INT_W = DEF_COMP_INT_W,
  parameter int unsigned SEC_W      = DEF_SEC_W,
  parameter int unsigned HALF_W     = DEF_HALF_W,
  localparam int unsigned COMP_W    = COMP_INT_W + FRAC_W,
  localparam int unsigned STAMP_W   = SEC_W + STAMP_NS_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               comp_wr_en,
  input logic [COMP_W-1:0]  comp_wr_data,
  input logic               load_en,
  input logic [SEC_W-1:0]   load_sec,
  input logic [NS_W-1:0]    load_ns,
  input logic               pps_wr_en,
  input logic [HALF_W-1:0]  pps_hi_ns,
  input logic [HALF_W-1:0]  pps_lo_ns,
  input logic               snap_req,
  input logic               snap_valid,
  input logic [STAMP_W-1:0] snap_ts,
  input logic               sec_tick,
  input logic [NS_W-1:0]    ns_q,
  input logic [FRAC_W-1:0]  frac_q,
  input logic [SEC_W-1:0]   sec_q
);
  AST_COMP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    comp_wr_en |-> (comp_wr_data[COMP_W-1:FRAC_W] < COMP_INT_W'(NS_PER_SEC))); // R1

  AST_LOAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (32'(load_ns) < NS_PER_SEC)); // R6

  AST_PPS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pps_wr_en |-> ((HALF_W+1)'(pps_hi_ns) + (HALF_W+1)'(pps_lo_ns) != '0)); // R8

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ns_q) < NS_PER_SEC); // R2

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (sec_q == $past(sec_q) || sec_q == SEC_W'($past(sec_q) + 1'b1))); // R4

  AST_TICK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (sec_tick == (sec_q != $past(sec_q)))); // R4

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sec_q == $past(load_sec) && ns_q == $past(load_ns)
                 && frac_q == '0 && !sec_tick)); // R6

  AST_SNAP_VALID_HI: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_valid); // R7

  AST_SNAP_VALID_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> !snap_valid); // R7

  AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_ts == {$past(sec_q), STAMP_NS_W'($past(ns_q))})); // R7
endmodule

bind ptp_tod_counter ptp_tod_checker #(
  .NS_W       (NS_W),
  .FRAC_W     (FRAC_W),
  .COMP_INT_W (COMP_INT_W),
  .SEC_W      (SEC_W),
  .HALF_W     (HALF_W)
) u_tod_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .comp_wr_en   (comp_wr_en),
  .comp_wr_data (comp_wr_data),
  .load_en      (load_en),
  .load_sec     (load_sec),
  .load_ns      (load_ns),
  .pps_wr_en    (pps_wr_en),
  .pps_hi_ns    (pps_hi_ns),
  .pps_lo_ns    (pps_lo_ns),
  .snap_req     (snap_req),
  .snap_valid   (snap_valid),
  .snap_ts      (snap_ts),
  .sec_tick     (sec_tick),
  .ns_q         (ns_q),
  .frac_q       (frac_q),
  .sec_q        (sec_q)
);

// File: tb/ptp_tod_counter_bench.sv
`timescale 1ns/1ps
module ptp_tod_counter_bench;
  logic        clk;
  logic        rst_n;
  logic        comp_wr_en;
  logic [63:0] comp_wr_data;
  logic        load_en;
  logic [31:0] load_sec;
  logic [29:0] load_ns;
  logic        pps_wr_en;
  logic [31:0] pps_hi_ns;
  logic [31:0] pps_lo_ns;
  logic        snap_req;
  logic        snap_valid;
  logic [63:0] snap_ts;
  logic        sec_tick;
  logic        pps_out;

  int n_chk;
  int n_err;
  bit done;

  // reference model state
  logic [31:0] m_ns, m_frac, m_sec, m_hi, m_lo;
  logic [63:0] m_comp;
  logic [64:0] m_ph;
  logic        exp_tick, exp_pps;
  logic [63:0] exp_ts;

  localparam logic [32:0] SEC_NS = 33'd1_000_000_000;

  ptp_tod_counter u_ptp_tod_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .comp_wr_en   (comp_wr_en),
    .comp_wr_data (comp_wr_data),
    .load_en      (load_en),
    .load_sec     (load_sec),
    .load_ns      (load_ns),
    .pps_wr_en    (pps_wr_en),
    .pps_hi_ns    (pps_hi_ns),
    .pps_lo_ns    (pps_lo_ns),
    .snap_req     (snap_req),
    .snap_valid   (snap_valid),
    .snap_ts      (snap_ts),
    .sec_tick     (sec_tick),
    .pps_out      (pps_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs held, model advanced at the edge, outputs checked at the falling edge
  task automatic step();
    logic [64:0] acc;
    logic [32:0] per;
    logic        wrp;
    @(posedge clk);
    if (snap_req) exp_ts = {m_sec, m_ns};
    wrp = 1'b0;
    if (load_en) begin
      m_ns = {2'b00, load_ns};
      m_frac = '0;
      m_sec = load_sec;
    end else begin
      acc = {1'b0, m_ns, m_frac} + {1'b0, m_comp};
      if (acc[64:32] >= SEC_NS) begin
        acc = acc - {SEC_NS, 32'd0};
        wrp = 1'b1;
        m_sec = m_sec + 32'd1;
      end
      m_ns = acc[63:32];
      m_frac = acc[31:0];
    end
    per = {1'b0, m_hi} + {1'b0, m_lo};
    if (load_en || wrp) begin
      m_ph = {1'b0, m_ns, m_frac};
    end else begin
      m_ph = m_ph + {1'b0, m_comp};
      if (m_ph[64:32] >= per) m_ph = m_ph - {per, 32'd0};
    end
    if (pps_wr_en) begin
      m_hi = pps_hi_ns;
      m_lo = pps_lo_ns;
    end
    if (comp_wr_en) m_comp = comp_wr_data;
    exp_tick = wrp;
    exp_pps = (m_ph[64:32] < {1'b0, m_hi});
    @(negedge clk);
    chk(sec_tick == exp_tick, "R4 sec_tick", 64'(sec_tick), 64'(exp_tick));
    chk(snap_valid == snap_req, "R7 snap_valid", 64'(snap_valid), 64'(snap_req));
    if (snap_req) chk(snap_ts == exp_ts, "R7 snap_ts", snap_ts, exp_ts);
    chk(pps_out == exp_pps, "R8 pps_out", 64'(pps_out), 64'(exp_pps));
    comp_wr_en = 1'b0;
    load_en = 1'b0;
    pps_wr_en = 1'b0;
    snap_req = 1'b0;
  endtask

  task automatic snapx(input logic [31:0] es, input logic [31:0] en, input string tag);
    snap_req = 1'b1;
    step();
    chk(snap_ts == {es, en}, tag, snap_ts, {es, en});
  endtask

  task automatic do_load(input logic [31:0] s, input logic [29:0] n);
    load_en = 1'b1;
    load_sec = s;
    load_ns = n;
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    done = 1'b0;
    rst_n = 1'b0;
    comp_wr_en = 1'b0;
    comp_wr_data = '0;
    load_en = 1'b0;
    load_sec = '0;
    load_ns = '0;
    pps_wr_en = 1'b0;
    pps_hi_ns = '0;
    pps_lo_ns = '0;
    snap_req = 1'b0;
    m_ns = '0; m_frac = '0; m_sec = '0;
    m_hi = 32'd500_000_000; m_lo = 32'd500_000_000;
    m_comp = 64'h0000_0008_0000_0000;
    m_ph = '0;
    exp_ts = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // R10: reset state
    chk(snap_valid == 1'b0, "R10 snap_valid after reset", 64'(snap_valid), 0);
    chk(sec_tick == 1'b0, "R10 sec_tick after reset", 64'(sec_tick), 0);
    chk(pps_out == 1'b1, "R10 pps_out after reset", 64'(pps_out), 1);
    snapx(32'd0, 32'd0, "R10 time after reset");

    // R1: default 8 ns increment
    step();
    step();
    snapx(32'd0, 32'd24, "R1 default increment");

    // R2/R3: hold at 999999999, then wrap keeping the excess
    do_load(32'd5, 30'd999_999_991);
    step();
    step();
    snapx(32'd5, 32'd999_999_999, "R2 no early wrap");
    chk(sec_tick == 1'b1, "R4 tick on wrap", 64'(sec_tick), 1);
    snapx(32'd6, 32'd7, "R3 excess kept");

    // R2: exactly one second wraps to zero
    do_load(32'd9, 30'd999_999_984);
    step();
    step();
    step();
    snapx(32'd10, 32'd0, "R2 exact limit");

    // R5: increment change keeps the fraction
    do_load(32'd0, 30'd0);
    comp_wr_en = 1'b1;
    comp_wr_data = 64'h0000_0001_8000_0000;
    step();
    comp_wr_en = 1'b1;
    comp_wr_data = 64'h0000_0002_8000_0000;
    step();
    step();
    snapx(32'd0, 32'd4, "R5 new increment next cycle");
    snapx(32'd0, 32'd6, "R5 fraction carried");

    // R6/R7: load with snapshot in the same cycle
    do_load(32'd77, 30'd123);
    snapx(32'd0, 32'd9, "R7 snapshot before load");
    snapx(32'd77, 32'd123, "R6 load replaces accumulation");

    // R9: PPS realigned at the wrap
    do_load(32'd0, 30'd0);
    comp_wr_en = 1'b1;
    comp_wr_data = 64'h05F5_E100_0000_0000;
    pps_wr_en = 1'b1;
    pps_hi_ns = 32'd300_000_000;
    pps_lo_ns = 32'd300_000_000;
    step();
    for (int k = 1; k <= 9; k++) step();
    chk(pps_out == 1'b0, "R8 phase past high duration", 64'(pps_out), 0);
    step();
    chk(sec_tick == 1'b1, "R4 tick at boundary", 64'(sec_tick), 1);
    chk(pps_out == 1'b1, "R9 pps rises at wrap", 64'(pps_out), 1);

    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 10 == 0) begin
        comp_wr_en = 1'b1;
        comp_wr_data = {32'($urandom % 300_000_000), 32'($urandom)};
      end
      if ($urandom % 20 == 0) do_load($urandom, 30'($urandom % 1_000_000_000));
      if ($urandom % 20 == 0) begin
        pps_wr_en = 1'b1;
        pps_hi_ns = 32'd200_000_000 + ($urandom % 400_000_000);
        pps_lo_ns = 32'd200_000_000 + ($urandom % 400_000_000);
      end
      snap_req = $urandom % 2 == 0;
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule